// File: doc/BRIEF.md
# Dual-Copy Register File Behind an I2C Target

This block is an I2C target interface in front of a four-entry, byte-wide register file. The file is held twice: a working (volatile) copy that reads always return, and a persistent copy that stands in for non-volatile storage. SCL and SDA enter through two-flop synchronizers. START and STOP conditions and the SCL edges are then found in the system clock domain. The block answers to one fixed 7-bit device address, takes a register address byte, and then either accepts a single data byte or returns data bytes in sequence. It pulls SDA low through an open-drain enable output.

Register 2, bit 7 picks where a write lands. Set to 1, only the working copy is updated. Set to 0, both copies are updated and a timed busy period starts. During that period the block releases SDA and ignores all bus activity. When the period ends, the whole working copy is reloaded from the persistent copy. A data byte takes effect only on a clean STOP that directly follows its acknowledge. A write-allow input must be high for the data byte to be accepted.

Top module: `i2c_dualcopy_slave`

## Requirements
- R1: The first byte after a START is acknowledged only when its upper seven bits equal DEV_ADDR; bit 0 is the direction (0 write, 1 read). On a mismatch there is no ACK, and the block ignores the bus until the next START.
- R2: The register address byte is acknowledged only when its upper six bits are zero, and its low two bits become the register pointer. Any other value gets no ACK and changes no register.
- R3: With wr_allow high, the data byte is acknowledged and written to the addressed register, and the write takes effect only when a STOP directly follows the data ACK.
- R4: With wr_allow low when the eighth data bit is taken, the data byte gets no ACK and no register changes.
- R5: A repeated START after the data ACK, or any extra SCL pulse between the data ACK and the STOP, discards the write, and neither copy changes.
- R6: When bit 7 of register 2 is 1, a write updates only the working copy and starts no busy period, so the next address byte is acknowledged at once. The mode used is the value register 2 holds before the write.
- R7: When bit 7 of register 2 is 0, a write updates both copies and starts a busy period of exactly NV_BUSY_CYCLES clocks. During it sda_pull stays low and even a matching address gets no ACK.
- R8: In the clock after the busy period ends, every working register equals its persistent counterpart.
- R9: A read is a write of the register address, a repeated START and the device address with bit 0 set. Bytes are sent MSB first from the pointer, and the pointer advances after each byte, wrapping from 3 to 0. A master NACK ends the read.
- R10: sda_pull changes only while the synchronized SCL is low. START is SDA falling and STOP is SDA rising, each while SCL is high.
- R11: After reset all registers of both copies are 0x00, sda_pull is low and no busy period runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| wr_allow | input | 1 | High permits data bytes to be accepted |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A STOP that commits a write can also change the mode register whose value picks the destination of that same write. The mode must then come from the value register 2 held before the write. The bench provokes this twice. It writes 0x80 to register 2 while in two-copy mode, which must still start a busy period. It then writes 0x00 to register 2 while in working-only mode, which must not start one. The outcome is judged at the pins: the bench checks whether a device address sent right after the STOP is acknowledged. After a later reload, it reads back whether the persistent copy took each value.

// File: rtl/i2c_dc_pkg.sv
`timescale 1ns/1ps
package i2c_dc_pkg;

    localparam int BYTE_W   = 8;
    localparam int MODE_REG = 2;
    localparam int MODE_BIT = 7;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic wr_allow;
    } bus_evt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_WAIT_STOP,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    function automatic logic id_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync
    import i2c_dc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    input  logic     wr_allow,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh, sda_sh, wa_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            wa_sh  <= '0;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            wa_sh  <= {wa_sh[STAGES-2:0], wr_allow};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        evt.scl_lvl  = scl_sh[STAGES-1];
        evt.sda_lvl  = sda_sh[STAGES-1];
        evt.wr_allow = wa_sh[STAGES-1];
        evt.scl_rise = evt.scl_lvl & ~scl_d;
        evt.scl_fall = ~evt.scl_lvl & scl_d;
        evt.start    = evt.scl_lvl & scl_d & sda_d & ~evt.sda_lvl;
        evt.stop     = evt.scl_lvl & scl_d & ~sda_d & evt.sda_lvl;
    end
endmodule

// File: rtl/i2c_proto_fsm.sv
`timescale 1ns/1ps
module i2c_proto_fsm
    import i2c_dc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         AW       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull
);
    bus_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, txreg;
    logic [AW-1:0]     ptr;
    logic              rw;

    assign rd_addr  = ptr;
    assign wr_valid = evt.stop & (state == ST_WAIT_STOP) & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_pull <= 1'b0;
        end else if (busy) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            state    <= ST_ID;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (evt.scl_rise) begin
            case (state)
                ST_ID, ST_ADDR, ST_WDATA: begin
                    shreg  <= {shreg[BYTE_W-2:0], evt.sda_lvl};
                    bitcnt <= bitcnt + 4'd1;
                end
                ST_RDATA: bitcnt <= bitcnt + 4'd1;
                ST_RD_ACK: begin
                    if (evt.sda_lvl) begin
                        state <= ST_IGNORE;
                    end else begin
                        txreg  <= rd_data;
                        ptr    <= ptr + 1'b1;
                        bitcnt <= '0;
                        state  <= ST_RDATA;
                    end
                end
                default: ;
            endcase
        end else if (evt.scl_fall) begin
            case (state)
                ST_ID: if (bitcnt == 4'd8) begin
                    if (id_hit(shreg, DEV_ADDR)) begin
                        sda_pull <= 1'b1;
                        rw       <= shreg[0];
                        state    <= ST_ID_ACK;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_ADDR: if (bitcnt == 4'd8) begin
                    if (shreg[BYTE_W-1:AW] == '0) begin
                        sda_pull <= 1'b1;
                        ptr      <= shreg[AW-1:0];
                        state    <= ST_ADDR_ACK;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_WDATA: if (bitcnt == 4'd8) begin
                    if (evt.wr_allow) begin
                        sda_pull <= 1'b1;
                        wr_data  <= shreg;
                        state    <= ST_WDATA_ACK;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_ID_ACK: begin
                    bitcnt <= '0;
                    if (rw) begin
                        txreg    <= rd_data << 1;
                        sda_pull <= ~rd_data[BYTE_W-1];
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RDATA;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_ADDR;
                    end
                end
                ST_ADDR_ACK: begin
                    sda_pull <= 1'b0;
                    bitcnt   <= '0;
                    wr_addr  <= ptr;
                    state    <= ST_WDATA;
                end
                ST_WDATA_ACK: begin
                    sda_pull <= 1'b0;
                    state    <= ST_WAIT_STOP;
                end
                ST_WAIT_STOP: state <= ST_IGNORE;
                ST_RDATA: begin
                    if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                        state    <= ST_RD_ACK;
                    end else begin
                        sda_pull <= ~txreg[BYTE_W-1];
                        txreg    <= txreg << 1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dual_copy_regs.sv
`timescale 1ns/1ps
module dual_copy_regs
    import i2c_dc_pkg::*;
#(
    parameter int NREG        = 4,
    parameter int BUSY_CYCLES = 1000,
    localparam int AW = $clog2(NREG),
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_valid,
    input  logic [AW-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [BYTE_W-1:0]      rd_data,
    output logic                   busy,
    output logic                   reload,
    output logic [NREG*BYTE_W-1:0] vol_flat,
    output logic [NREG*BYTE_W-1:0] nv_flat
);
    logic [BYTE_W-1:0] vol [NREG];
    logic [BYTE_W-1:0] nv  [NREG];
    logic [CW-1:0]     cnt;
    logic              vol_only;

    assign vol_only = vol[MODE_REG][MODE_BIT];
    assign reload   = busy && (cnt == CW'(1));
    assign rd_data  = vol[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                vol[i] <= '0;
                nv[i]  <= '0;
            end
            busy <= 1'b0;
            cnt  <= '0;
        end else if (wr_valid) begin
            vol[wr_addr] <= wr_data;
            if (!vol_only) begin
                nv[wr_addr] <= wr_data;
                busy        <= 1'b1;
                cnt         <= CW'(BUSY_CYCLES);
            end
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (reload) begin
                busy <= 1'b0;
                for (int i = 0; i < NREG; i++) vol[i] <= nv[i];
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign vol_flat[g*BYTE_W +: BYTE_W] = vol[g];
        assign nv_flat[g*BYTE_W +: BYTE_W]  = nv[g];
    end
endmodule

// File: rtl/i2c_dualcopy_slave.sv
`timescale 1ns/1ps
module i2c_dualcopy_slave
    import i2c_dc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR       = 7'h50,
    parameter int         NREG           = 4,
    parameter int         NV_BUSY_CYCLES = 1000,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_allow,
    output logic sda_pull
);
    localparam int AW = $clog2(NREG);

    bus_evt_t                 evt;
    logic                     nv_busy, nv_reload, wr_valid;
    logic [AW-1:0]            wr_addr, rd_addr;
    logic [BYTE_W-1:0]        wr_data, rd_data;
    logic [NREG*BYTE_W-1:0]   vol_flat, nv_flat;
    logic                     scl_lvl_w, stop_w;

    assign scl_lvl_w = evt.scl_lvl;
    assign stop_w    = evt.stop;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .wr_allow(wr_allow), .evt(evt)
    );

    i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .busy(nv_busy),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull(sda_pull)
    );

    dual_copy_regs #(.NREG(NREG), .BUSY_CYCLES(NV_BUSY_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(nv_busy), .reload(nv_reload), .vol_flat(vol_flat),
        .nv_flat(nv_flat)
    );
endmodule

// File: rtl/i2c_dualcopy_chk.sv
`timescale 1ns/1ps
module i2c_dualcopy_chk #(
    parameter int NREG        = 4,
    parameter int BUSY_CYCLES = 1000,
    localparam int FW = NREG * 8,
    localparam int BW = $clog2(BUSY_CYCLES + 1) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_pull,
    input logic          scl_lvl,
    input logic          stop_evt,
    input logic          busy,
    input logic          reload,
    input logic [FW-1:0] vol_flat,
    input logic [FW-1:0] nv_flat
);
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    // R7
    busy_max_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt < BW'(BUSY_CYCLES)));

    // R7
    busy_exact_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (bcnt == BW'(BUSY_CYCLES)));

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_lvl);

    // R3
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    // R5
    vol_change_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vol_flat) |-> ($past(stop_evt) || $past(reload)));

    // R8
    reload_match_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reload) |-> (vol_flat == $past(nv_flat)));
endmodule

bind i2c_dualcopy_slave i2c_dualcopy_chk #(
    .NREG(NREG), .BUSY_CYCLES(NV_BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .sda_pull(sda_pull), .scl_lvl(scl_lvl_w),
    .stop_evt(stop_w), .busy(nv_busy), .reload(nv_reload),
    .vol_flat(vol_flat), .nv_flat(nv_flat)
);

// File: tb/tb_i2c_dualcopy_slave.sv
`timescale 1ns/1ps
module tb_i2c_dualcopy_slave;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 600;
    localparam int         Q    = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic scl = 1'b1, sda_m = 1'b1, wr_allow = 1'b1;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    i2c_dualcopy_slave #(.DEV_ADDR(DEV), .NV_BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .wr_allow(wr_allow), .sda_pull(sda_pull)
    );

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q/2);
        ack = ~sda_line;
        wq(Q/2); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q/2); b[i] = sda_line; wq(Q/2); scl = 1'b0;
        end
        wq(Q/2); sda_m = ~give_ack; wq(Q/2);
        scl = 1'b1; wq(Q); scl = 1'b0; wq(Q/2); sda_m = 1'b1;
    endtask

    // full single-byte write; returns the three acknowledges
    task automatic write_reg(input logic [7:0] a, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(a, a1);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic read_check(input logic [7:0] a, input int n, input logic [7:0] exp [8], input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, {req, " read: id ack"}, ack, 1);
        send_byte(a, ack);
        chk(ack, {req, " read: addr ack"}, ack, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        chk(ack, {req, " read: id(r) ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(b === exp[k], {req, " read data"}, b, exp[k]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] e [8];
        e = '{default: 8'h00};
        chk(sda_pull == 1'b0, "R11 pull idle after reset", sda_pull, 0);
        read_check(8'h00, 4, e, "R11 registers zero");
    endtask

    task automatic t_bad_id();
        bit ack;
        bus_start();
        send_byte({7'h23, 1'b0}, ack);
        chk(!ack, "R1 wrong id not acked", ack, 0);
        send_byte(8'h01, ack);
        chk(!ack, "R1 ignored until START", ack, 0);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        bit a0, a1, a2;
        logic [7:0] e [8];
        write_reg(8'h04, 8'hEE, a0, a1, a2);
        chk(a0, "R2 id acked", a0, 1);
        chk(!a1, "R2 addr 0x04 not acked", a1, 0);
        e = '{default: 8'h00};
        read_check(8'h00, 1, e, "R2 reg0 unchanged");
    endtask

    task automatic t_nv_write();
        bit a0, a1, a2, ack;
        logic [7:0] e [8];
        write_reg(8'h00, 8'hA5, a0, a1, a2);
        chk(a2, "R3 data acked", a2, 1);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(!ack, "R7 id not acked while busy", ack, 0);
        chk(sda_pull == 1'b0, "R7 sda released while busy", sda_pull, 0);
        bus_stop();
        wq(BUSY + 100);
        e = '{default: 8'h00};
        e[0] = 8'hA5;
        read_check(8'h00, 1, e, "R3 R8 reg0 after commit");
    endtask

    task automatic t_protect();
        bit a0, a1, a2;
        logic [7:0] e [8];
        wr_allow = 1'b0;
        wq(5);
        write_reg(8'h01, 8'h33, a0, a1, a2);
        chk(a1, "R4 addr still acked", a1, 1);
        chk(!a2, "R4 data not acked", a2, 0);
        wr_allow = 1'b1;
        wq(BUSY + 100);
        e = '{default: 8'h00};
        read_check(8'h01, 1, e, "R4 reg1 unchanged");
    endtask

    task automatic t_abort();
        bit ack;
        logic [7:0] e [8];
        // repeated START in place of STOP
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h01, ack);
        send_byte(8'h77, ack);
        chk(ack, "R5 data acked before abort", ack, 1);
        bus_start();
        bus_stop();
        wq(BUSY + 100);
        e = '{default: 8'h00};
        read_check(8'h01, 1, e, "R5 restart discards write");
        // extra SCL pulse before STOP
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h01, ack);
        send_byte(8'h66, ack);
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
        bus_stop();
        wq(BUSY + 100);
        read_check(8'h01, 1, e, "R5 extra pulse discards write");
    endtask

    task automatic t_modes();
        bit a0, a1, a2, ack;
        logic [7:0] e [8];
        // still two-copy mode: writing 0x80 to reg2 must start a busy period
        write_reg(8'h02, 8'h80, a0, a1, a2);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(!ack, "R6 mode from old reg2 value (busy)", ack, 0);
        bus_stop();
        wq(BUSY + 100);
        // working-only mode now
        write_reg(8'h01, 8'h55, a0, a1, a2);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R6 no busy in working-only mode", ack, 1);
        bus_stop();
        e = '{default: 8'h00};
        e[0] = 8'h55;
        read_check(8'h01, 1, e, "R6 working copy written");
        // back to two-copy mode: the write itself stays working-only
        write_reg(8'h02, 8'h00, a0, a1, a2);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R6 reg2 clear uses old mode (no busy)", ack, 1);
        bus_stop();
        write_reg(8'h03, 8'h3C, a0, a1, a2);
        chk(a2, "R7 data acked", a2, 1);
        wq(BUSY + 100);
        // reload: reg1 back to 0, reg2 back to 0x80; wrap 3 -> 0
        e[0] = 8'hA5; e[1] = 8'h00; e[2] = 8'h80; e[3] = 8'h3C; e[4] = 8'hA5; e[5] = 8'h00;
        read_check(8'h00, 6, e, "R8 R9 reload and wrap");
        e[0] = 8'h3C; e[1] = 8'hA5;
        read_check(8'h03, 2, e, "R9 wrap from 3");
    endtask

    initial begin
        wq(10);
        rst = 1'b0;
        wq(10);
        t_reset();
        t_bad_id();
        t_bad_addr();
        t_nv_write();
        t_protect();
        t_abort();
        t_modes();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule